// File: doc/BRIEF.md
# Embedded Controller Mailbox Interrupt Sequencer

This block is the command engine that sits behind a one-byte host mailbox of an embedded controller. The host writes bytes to either a command port or a data port and reads bytes back from a single output buffer. A status byte reports the input-buffer-full and output-buffer-full flags, the port of the last write, the burst state and a pending event flag. The engine follows multi-byte transactions: register read, register write, event query, burst enable and burst disable. On the local side it drives a register address, write strobes and write data. It samples read data, and it takes event requests that carry a cause code.

The host learns about progress through one dedicated interrupt line. This line carries a pulse of fixed width and never a held level, so the host can treat it as an edge. A pulse is raised only on particular bytes of each transaction, and not on every flag change. It is also raised once when a new event becomes pending. Requests that arrive close together are counted. Each one later comes out as a pulse of its own, with low time between pulses.

Top module: `ec_sci_seq`

## Requirements
- R1: After a synchronous active-low reset the status byte is 0x00, the interrupt line is low and the output buffer is 0x00.
- R2: Status bit 1 is the input-full flag and bit 3 is the command flag. A host write sets bit 1. It sets bit 3 for the command port and clears it for the data port. The engine consumes the byte in the next cycle, which clears bit 1 when no new write arrives.
- R3: Each interrupt pulse is high for exactly PULSE_W clocks (default 4). After a pulse the line stays low for at least GAP_W clocks (default 1).
- R4: Read (command 0x80): the command byte gives one pulse. The address byte gives one pulse, with the returned byte `lcl_rd_data` sampled at `lcl_addr` and placed in the output buffer, which sets status bit 0 (output full).
- R5: Write (command 0x81): the command byte, the address byte and the data byte each give one pulse. The data byte drives one `lcl_wr_en` cycle with that address and data.
- R6: Query (command 0x84): the command byte gives one pulse, for the response. The response is the pending event code, or 0x00 if none is pending. The query clears status bit 5 (event pending).
- R7: Burst enable (0x82) gives one pulse, loads 0x90 as its acknowledge and sets status bit 4. Burst disable (0x83) gives one pulse and clears bit 4.
- R8: An event request while none is pending sets status bit 5, latches its code and gives one pulse. A request while one is pending gives no pulse and leaves the latched code unchanged.
- R9: A host read of the data port clears status bit 0.
- R10: An unknown command code, or a data byte with no transaction open, is consumed with no pulse and leaves the engine idle.
- R11: Two interrupt requests raised in the same cycle give two separate pulses.
- R12: A command byte that arrives in the middle of a transaction abandons that transaction. No local write occurs for it, and the new command is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | One-cycle host write strobe |
| host_is_cmd | input | 1 | 1 selects the command port for a write, 0 the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | One-cycle host read strobe for the data port |
| host_rdata | output | 8 | Output buffer contents |
| status | output | 8 | Bit0 output full, bit1 input full, bit3 command flag, bit4 burst, bit5 event pending; others zero |
| sci | output | 1 | Pulsed interrupt to the host |
| lcl_addr | output | 8 | Local register address for reads and writes |
| lcl_rd_data | input | 8 | Local read data, sampled while a read address byte is consumed |
| lcl_wr_en | output | 1 | One-cycle local write strobe |
| lcl_wdata | output | 8 | Local write data |
| lcl_evt_set | input | 1 | One-cycle event request |
| lcl_evt_code | input | 8 | Cause code that goes with an event request |

## Verification
The hardest case to reach is two interrupt requests landing in the same clock, one from a consumed byte and one from a new event. Only then does the request counter take two at once. The stimulus lines this up by raising the event request exactly one cycle after a host command write, which is the cycle the engine consumes that byte. The scoreboard then expects two distinct pulses of full width. The bench also breaks open transactions with a fresh command byte, and it fires a second event while one is pending. These steps show that such bytes and requests leave no trace on the line or in the status byte.

// File: rtl/ec_sci_pkg.sv
// Shared codes, status bit positions and state types for the mailbox
// interrupt sequencer. Assumes one-byte host ports.
package ec_sci_pkg;
    localparam logic [7:0] OP_READ      = 8'h80;
    localparam logic [7:0] OP_WRITE     = 8'h81;
    localparam logic [7:0] OP_BURST_ON  = 8'h82;
    localparam logic [7:0] OP_BURST_OFF = 8'h83;
    localparam logic [7:0] OP_QUERY     = 8'h84;
    localparam logic [7:0] BURST_ACK    = 8'h90;

    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_CMD   = 3;
    localparam int ST_BURST = 4;
    localparam int ST_EVT   = 5;

    typedef enum logic [1:0] {
        TS_IDLE,
        TS_RD_ADDR,
        TS_WR_ADDR,
        TS_WR_DATA
    } txn_state_e;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_HIGH,
        PG_GAP
    } pulse_state_e;
endpackage

// File: rtl/ec_sci_host_buf.sv
// Host-facing byte buffers: input byte with full and port flags, output
// byte with full flag. Assumes the engine consumes any held input byte
// in the cycle after it arrives.
module ec_sci_host_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_is_cmd,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    input  logic          consume,
    input  logic          ob_load,
    input  logic [DW-1:0] ob_data,
    output logic [DW-1:0] ib_q,
    output logic          ibf_q,
    output logic          cmd_q,
    output logic [DW-1:0] ob_q,
    output logic          obf_q
);
    // Input side: a new write wins over the consume of an older byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ib_q  <= '0;
            ibf_q <= 1'b0;
            cmd_q <= 1'b0;
        end else if (host_wr) begin
            ib_q  <= host_wdata;
            ibf_q <= 1'b1;
            cmd_q <= host_is_cmd;
        end else if (consume) begin
            ibf_q <= 1'b0;
        end
    end

    // Output side: a load by the engine wins over a host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ob_q  <= '0;
            obf_q <= 1'b0;
        end else if (ob_load) begin
            ob_q  <= ob_data;
            obf_q <= 1'b1;
        end else if (host_rd) begin
            obf_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ec_sci_evt_latch.sv
// Holds one pending event and its cause code. Assumes a clear from a
// query and a new request may arrive together; the new request then
// becomes pending.
module ec_sci_evt_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_set,
    input  logic [DW-1:0] evt_code_in,
    input  logic          evt_clr,
    output logic          evt_pend_q,
    output logic [DW-1:0] evt_code_q,
    output logic          evt_req
);
    logic accept;

    // Accept a request when nothing is pending or the pending one is leaving.
    always_comb begin
        accept  = evt_set && (!evt_pend_q || evt_clr);
        evt_req = accept;
    end

    // Pending flag and code storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pend_q <= 1'b0;
            evt_code_q <= '0;
        end else if (accept) begin
            evt_pend_q <= 1'b1;
            evt_code_q <= evt_code_in;
        end else if (evt_clr) begin
            evt_pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ec_sci_txn_fsm.sv
// Transaction decoder. It consumes each held input byte in one cycle,
// tracks the open transaction, loads response bytes and raises an
// interrupt request on the bytes that call for one. Assumes a command
// byte always restarts decoding.
module ec_sci_txn_fsm
    import ec_sci_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ibf,
    input  logic          ib_is_cmd,
    input  logic [DW-1:0] ib_data,
    input  logic          evt_pend,
    input  logic [DW-1:0] evt_code,
    input  logic [DW-1:0] lcl_rd_data,
    output logic          consume,
    output logic          ob_load,
    output logic [DW-1:0] ob_data,
    output logic          evt_clr,
    output logic          sci_req,
    output logic          burst_q,
    output logic [DW-1:0] lcl_addr,
    output logic          lcl_wr_en,
    output logic [DW-1:0] lcl_wdata
);
    txn_state_e    state_q, state_n;
    logic [DW-1:0] addr_q, addr_n;
    logic          burst_n;

    // Next-state and per-byte action decode.
    always_comb begin
        state_n   = state_q;
        addr_n    = addr_q;
        burst_n   = burst_q;
        consume   = ibf;
        ob_load   = 1'b0;
        ob_data   = '0;
        evt_clr   = 1'b0;
        sci_req   = 1'b0;
        lcl_wr_en = 1'b0;
        if (ibf) begin
            if (ib_is_cmd) begin
                state_n = TS_IDLE;
                case (ib_data)
                    OP_READ: begin
                        state_n = TS_RD_ADDR;
                        sci_req = 1'b1;
                    end
                    OP_WRITE: begin
                        state_n = TS_WR_ADDR;
                        sci_req = 1'b1;
                    end
                    OP_BURST_ON: begin
                        burst_n = 1'b1;
                        ob_load = 1'b1;
                        ob_data = BURST_ACK;
                        sci_req = 1'b1;
                    end
                    OP_BURST_OFF: begin
                        burst_n = 1'b0;
                        sci_req = 1'b1;
                    end
                    OP_QUERY: begin
                        ob_load = 1'b1;
                        ob_data = evt_pend ? evt_code : '0;
                        evt_clr = evt_pend;
                        sci_req = 1'b1;
                    end
                    default: sci_req = 1'b0;
                endcase
            end else begin
                case (state_q)
                    TS_RD_ADDR: begin
                        ob_load = 1'b1;
                        ob_data = lcl_rd_data;
                        sci_req = 1'b1;
                        state_n = TS_IDLE;
                    end
                    TS_WR_ADDR: begin
                        addr_n  = ib_data;
                        sci_req = 1'b1;
                        state_n = TS_WR_DATA;
                    end
                    TS_WR_DATA: begin
                        lcl_wr_en = 1'b1;
                        sci_req   = 1'b1;
                        state_n   = TS_IDLE;
                    end
                    default: state_n = TS_IDLE;
                endcase
            end
        end
    end

    // Local address: the held write address for write data, else the byte.
    always_comb begin
        lcl_addr  = (state_q == TS_WR_DATA) ? addr_q : ib_data;
        lcl_wdata = ib_data;
    end

    // State, address and burst registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            addr_q  <= '0;
            burst_q <= 1'b0;
        end else begin
            state_q <= state_n;
            addr_q  <= addr_n;
            burst_q <= burst_n;
        end
    end
endmodule

// File: rtl/ec_sci_pulse_gen.sv
// Turns interrupt requests into pulses of PULSE_W clocks separated by at
// least GAP_W low clocks. Requests are counted, saturating at the
// counter maximum, and each counted request yields one pulse.
module ec_sci_pulse_gen
    import ec_sci_pkg::*;
#(
    parameter int PULSE_W = 4,
    parameter int GAP_W   = 1,
    parameter int QCNT_W  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic req_b,
    output logic sci_o
);
    localparam int TMAX = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [QCNT_W:0] PMAX = {1'b0, {QCNT_W{1'b1}}};

    pulse_state_e      ph_q;
    logic [CW-1:0]     cnt_q;
    logic [QCNT_W-1:0] pend_q;
    logic              start;
    logic [QCNT_W:0]   sum;

    // Start a pulse when requests wait and the line may go high.
    always_comb begin
        start = (pend_q != '0) &&
                ((ph_q == PG_IDLE) || ((ph_q == PG_GAP) && (cnt_q == '0)));
        sum   = {1'b0, pend_q} + (QCNT_W + 1)'(req_a) + (QCNT_W + 1)'(req_b)
                - (QCNT_W + 1)'(start);
    end

    // Waiting-request counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= '0;
        else if (sum > PMAX) pend_q <= PMAX[QCNT_W-1:0];
        else                 pend_q <= sum[QCNT_W-1:0];
    end

    // Pulse phase and width timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PG_IDLE;
            cnt_q <= '0;
        end else if (start) begin
            ph_q  <= PG_HIGH;
            cnt_q <= CW'(PULSE_W - 1);
        end else begin
            case (ph_q)
                PG_HIGH: begin
                    if (cnt_q == '0) begin
                        ph_q  <= PG_GAP;
                        cnt_q <= CW'(GAP_W - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PG_GAP: begin
                    if (cnt_q == '0) ph_q <= PG_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: ph_q <= PG_IDLE;
            endcase
        end
    end

    // Registered line drive.
    always_comb sci_o = (ph_q == PG_HIGH);
endmodule

// File: rtl/ec_sci_seq.sv
// Top of the mailbox interrupt sequencer: host buffers, transaction
// decoder, event latch and pulse generator, plus the status byte.
// Assumes one-cycle host strobes and read data valid while a read
// address byte is consumed.
module ec_sci_seq
    import ec_sci_pkg::*;
#(
    parameter int DW      = 8,
    parameter int PULSE_W = 4,
    parameter int GAP_W   = 1,
    parameter int QCNT_W  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_is_cmd,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    output logic [7:0]    status,
    output logic          sci,
    output logic [DW-1:0] lcl_addr,
    input  logic [DW-1:0] lcl_rd_data,
    output logic          lcl_wr_en,
    output logic [DW-1:0] lcl_wdata,
    input  logic          lcl_evt_set,
    input  logic [DW-1:0] lcl_evt_code
);
    logic [DW-1:0] ib_q, ob_data, evt_code_q;
    logic          ibf_q, cmd_q, obf_q, consume, ob_load;
    logic          evt_clr, evt_pend_q, evt_req, txn_req, burst_q;

    ec_sci_host_buf #(.DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_is_cmd(host_is_cmd), .host_wdata(host_wdata),
        .host_rd(host_rd), .consume(consume),
        .ob_load(ob_load), .ob_data(ob_data),
        .ib_q(ib_q), .ibf_q(ibf_q), .cmd_q(cmd_q),
        .ob_q(host_rdata), .obf_q(obf_q)
    );

    ec_sci_txn_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ibf(ibf_q), .ib_is_cmd(cmd_q), .ib_data(ib_q),
        .evt_pend(evt_pend_q), .evt_code(evt_code_q), .lcl_rd_data(lcl_rd_data),
        .consume(consume), .ob_load(ob_load), .ob_data(ob_data),
        .evt_clr(evt_clr), .sci_req(txn_req), .burst_q(burst_q),
        .lcl_addr(lcl_addr), .lcl_wr_en(lcl_wr_en), .lcl_wdata(lcl_wdata)
    );

    ec_sci_evt_latch #(.DW(DW)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .evt_set(lcl_evt_set), .evt_code_in(lcl_evt_code), .evt_clr(evt_clr),
        .evt_pend_q(evt_pend_q), .evt_code_q(evt_code_q), .evt_req(evt_req)
    );

    ec_sci_pulse_gen #(.PULSE_W(PULSE_W), .GAP_W(GAP_W), .QCNT_W(QCNT_W)) u_pulse (
        .clk(clk), .rst_n(rst_n),
        .req_a(txn_req), .req_b(evt_req), .sci_o(sci)
    );

    // Status byte assembly.
    always_comb begin
        status           = '0;
        status[ST_OBF]   = obf_q;
        status[ST_IBF]   = ibf_q;
        status[ST_CMD]   = cmd_q;
        status[ST_BURST] = burst_q;
        status[ST_EVT]   = evt_pend_q;
    end
endmodule

// File: rtl/ec_sci_seq_chk.sv
// Port-level property checker for the sequencer, bound to every instance.
module ec_sci_seq_chk #(
    parameter int PULSE_W = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_is_cmd,
    input logic       host_rd,
    input logic [7:0] status,
    input logic       sci
);
    logic [15:0] hi_cnt;

    // Length of the current high run of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)   hi_cnt <= '0;
        else if (sci) hi_cnt <= hi_cnt + 1'b1;
        else          hi_cnt <= '0;
    end

    a_r2_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> status[1] && (status[3] == $past(host_is_cmd)));

    a_r2_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !host_wr) |=> !status[1]);

    a_r3_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> (hi_cnt < 16'(PULSE_W)));

    a_r3_width_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sci) |-> (hi_cnt == 16'(PULSE_W)));

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !status[1]) |=> !status[0]);

    a_r8_evt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !status[1]) |=> status[5]);
endmodule

bind ec_sci_seq ec_sci_seq_chk #(.PULSE_W(PULSE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_is_cmd(host_is_cmd),
    .host_rd(host_rd), .status(status), .sci(sci)
);

// File: tb/ec_sci_seq_tb_top.sv
// Scoreboard bench: stimulus tasks queue one tag per expected pulse, and a
// monitor pops a tag for each pulse it sees and checks its width.
module ec_sci_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW         = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_is_cmd = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata, status;
    logic       sci, lcl_wr_en, lcl_evt_set = 1'b0;
    logic [7:0] lcl_addr, lcl_rd_data, lcl_wdata, lcl_evt_code = '0;

    int errors = 0;
    int checks = 0;
    int wr_seen = 0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    string exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Local register model: read data is the address xor 0xA5.
    assign lcl_rd_data = lcl_addr ^ 8'hA5;

    ec_sci_seq #(.PULSE_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_is_cmd(host_is_cmd),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .status(status), .sci(sci), .lcl_addr(lcl_addr), .lcl_rd_data(lcl_rd_data),
        .lcl_wr_en(lcl_wr_en), .lcl_wdata(lcl_wdata),
        .lcl_evt_set(lcl_evt_set), .lcl_evt_code(lcl_evt_code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: each pulse pops one expected tag and must be PW clocks wide.
    int hi_run = 0;
    logic sci_prev = 1'b0;
    always @(negedge clk) begin
        if (sci && !sci_prev) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected pulse: actual=1 expected=0");
            end else begin
                void'(exp_q.pop_front());
            end
        end
        if (sci) hi_run++;
        if (!sci && sci_prev) begin
            check("R3 pulse width", hi_run, PW);
            hi_run = 0;
        end
        sci_prev = sci;
    end

    // Capture of local write strobes.
    always @(negedge clk) begin
        if (lcl_wr_en) begin
            wr_seen++;
            wr_addr = lcl_addr;
            wr_data = lcl_wdata;
        end
    end

    task automatic hw(input logic is_cmd, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_is_cmd = is_cmd; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic evt(input logic [7:0] code);
        @(negedge clk);
        lcl_evt_set = 1'b1; lcl_evt_code = code;
        @(negedge clk);
        lcl_evt_set = 1'b0;
    endtask

    // Wait out all pulses, then require that every expected one was seen.
    task automatic settle(input string tag);
        repeat (30) @(negedge clk);
        check({tag, " pulses outstanding"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status", status, 8'h00);
        check("R1 sci", sci, 1'b0);
        check("R1 rdata", host_rdata, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: flags right after a write, before consume
        @(negedge clk);
        host_wr = 1'b1; host_is_cmd = 1'b1; host_wdata = 8'h99;
        @(negedge clk);
        host_wr = 1'b0;
        check("R2 ibf and cmd set", status, 8'h0A);
        settle("R10");
        check("R10 unknown cmd idle", status, 8'h08);

        // R4 read
        exp_q.push_back("R4");
        hw(1'b1, 8'h80);
        settle("R4");
        check("R4 after header", status, 8'h08);
        exp_q.push_back("R4");
        hw(1'b0, 8'h12);
        settle("R4");
        check("R4 obf set", status, 8'h01);
        check("R4 read data", host_rdata, 8'h12 ^ 8'hA5);
        hread();
        check("R9 read clears obf", status, 8'h00);

        // R5 write
        repeat (3) exp_q.push_back("R5");
        hw(1'b1, 8'h81);
        hw(1'b0, 8'h34);
        hw(1'b0, 8'h56);
        settle("R5");
        check("R5 write count", wr_seen, 1);
        check("R5 write addr", wr_addr, 8'h34);
        check("R5 write data", wr_data, 8'h56);

        // R6 query with nothing pending
        exp_q.push_back("R6");
        hw(1'b1, 8'h84);
        settle("R6");
        check("R6 empty query status", status, 8'h09);
        check("R6 empty query value", host_rdata, 8'h00);
        hread();

        // R8 event latch and ignore while pending
        exp_q.push_back("R8");
        evt(8'h4C);
        settle("R8");
        check("R8 evt pending", status, 8'h28);
        evt(8'h77);
        settle("R8 second");
        check("R8 still pending", status, 8'h28);
        exp_q.push_back("R6");
        hw(1'b1, 8'h84);
        settle("R6");
        check("R6 query clears evt", status, 8'h09);
        check("R8 first code kept", host_rdata, 8'h4C);
        hread();

        // R7 burst
        exp_q.push_back("R7");
        hw(1'b1, 8'h82);
        settle("R7");
        check("R7 burst on status", status, 8'h19);
        check("R7 burst ack", host_rdata, 8'h90);
        hread();
        exp_q.push_back("R7");
        hw(1'b1, 8'h83);
        settle("R7");
        check("R7 burst off status", status, 8'h08);

        // R10 stray data byte
        hw(1'b0, 8'h11);
        settle("R10");
        check("R10 stray data idle", status, 8'h00);
        check("R10 no write", wr_seen, 1);

        // R12 abandon a write with a query
        repeat (2) exp_q.push_back("R12");
        hw(1'b1, 8'h81);
        hw(1'b0, 8'h20);
        exp_q.push_back("R12");
        hw(1'b1, 8'h84);
        settle("R12");
        check("R12 query decoded", status, 8'h09);
        hread();
        hw(1'b0, 8'h05);
        settle("R12 tail");
        check("R12 no write", wr_seen, 1);
        check("R12 idle status", status, 8'h00);

        // R11 two requests in one cycle
        repeat (2) exp_q.push_back("R11");
        @(negedge clk);
        host_wr = 1'b1; host_is_cmd = 1'b1; host_wdata = 8'h83;
        @(negedge clk);
        host_wr = 1'b0;
        lcl_evt_set = 1'b1; lcl_evt_code = 8'h3E;
        @(negedge clk);
        lcl_evt_set = 1'b0;
        settle("R11");
        check("R11 status", status, 8'h28);
        exp_q.push_back("R6");
        hw(1'b1, 8'h84);
        settle("R6");
        check("R6 second code", host_rdata, 8'h3E);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule